// File: doc/BRIEF.md
# Hex Text Device Bus Bridge

This block turns single bus accesses into short ASCII command lines for a device that sits on the far end of a byte stream, such as a serial port. Each accepted request is written out as a command letter, a space and a zero-padded hexadecimal address. Writes add a second space and the hexadecimal data. A newline closes every line. The block then waits for the device's answer line. It returns the read data, a one-cycle completion strobe and an error flag.

The answer can be a success line, which carries the read value for reads, or a refusal line. An interrupt notice line can also arrive at any moment, even while no access is pending. The notice produces a one-cycle interrupt pulse and never completes an access. A programmable cycle limit ends an access that gets no answer. Malformed answer text ends the access at once with the error flag set.

Top module: `hexlink_bridge`

## Requirements
- R1: A read sends one of three letters, chosen by `req_size`: 'h' for code 0 (high byte), 'l' for code 1 (low byte), 'w' for codes 2 and 3 (word). The letter is followed by a space, the address as 7 hex digits with the most significant digit first and leading zeros kept, and a newline.
- R2: A write sends the uppercase letter ('H', 'L' or 'W', with the same size codes) followed by a space, the 7 address digits and a space. Then come 2 hex digits of `req_wdata[7:0]` for byte sizes, or 4 digits of `req_wdata[15:0]` for word sizes, and a newline.
- R3: Every hex digit the block sends uses uppercase letters A to F.
- R4: While `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change. Each byte is sent once, in the cycle `tx_valid` and `tx_ready` are both high.
- R5: A read answered with 'o', a space, 2 hex digits (byte sizes) or 4 hex digits (word sizes) and a newline completes with `err` low. `rd_data` then holds the value, zero-extended for bytes. Digits a to f are accepted in either case.
- R6: A write answered with 'o' and a newline completes with `err` low and `rd_data` zero.
- R7: An answer of 'x' and a newline completes the access with `err` high. `rd_data` is then 0x00FF for byte sizes and 0xFFFF for word sizes.
- R8: Any unexpected character in an answer completes the access. The completion comes on the clock edge that takes that character, with `err` high and the same fill value as R7.
- R9: An 'i' received where a new line begins raises `irq_pulse` for one cycle after that byte. This holds whether an access is pending or not. A pending access keeps waiting.
- R10: Suppose no answer completes the access. Then `done` rises with `err` high and the R7 fill value on the (`tmo_limit`+1)-th rising edge after the edge that takes the last command byte.
- R11: `req_ready` is high only while no access is in progress. Bytes other than 'i' that arrive while idle produce no completion.
- R12: `done` is high for exactly one cycle per access. `rd_data` and `err` hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Bridge idle, request taken when both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 high byte, 1 low byte, 2 or 3 word |
| req_addr | input | 28 | Access address |
| req_wdata | input | 16 | Write data |
| tmo_limit | input | 16 | Answer wait limit in cycles |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Outgoing byte taken |
| tx_data | output | 8 | Outgoing ASCII byte |
| rx_valid | input | 1 | Incoming byte valid for one cycle |
| rx_data | input | 8 | Incoming ASCII byte |
| done | output | 1 | Access completion strobe |
| err | output | 1 | Completed access failed |
| rd_data | output | 16 | Read result or fill value |
| irq_pulse | output | 1 | Interrupt notice received |

## Verification
Some properties are checked on every cycle: a stalled byte stays stable, no lowercase hex leaves the block, the completion strobe is one cycle wide and returns the bridge to idle, error completions carry a fill value, the wait counter steps cleanly, and an interrupt pulse always follows an 'i' byte. Other behaviour only the scenarios can show. These are the exact text of every command for each direction, size code and extreme address or data value, and the parsing of mixed-case answers. They also cover interrupts that arrive mid-wait or while idle, stray idle bytes, and the precise cycle on which a timeout completes.

// File: rtl/hexlink_pkg.sv
package hexlink_pkg;
   localparam int DATA_W = 16;
   localparam logic [7:0] ASC_SP  = 8'h20;
   localparam logic [7:0] ASC_NL  = 8'h0A;
   localparam logic [7:0] ASC_OK  = 8'h6F;
   localparam logic [7:0] ASC_BAD = 8'h78;
   localparam logic [7:0] ASC_IRQ = 8'h69;

   typedef enum logic [1:0] {CTL_IDLE, CTL_SEND, CTL_WAIT} ctl_state_t;
   typedef enum logic [2:0] {PRS_LEAD, PRS_SEP, PRS_DIG, PRS_END_OK,
                             PRS_END_BAD, PRS_END_IRQ} prs_state_t;

   // nibble to uppercase ASCII hex digit
   function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
      return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
   endfunction

   // ASCII hex digit (either case) to {valid, nibble}
   function automatic logic [4:0] ascii_to_nib(input logic [7:0] c);
      logic [4:0] r;
      if (c >= 8'h30 && c <= 8'h39)
         r = {1'b1, c[3:0]};
      else if ((c >= 8'h41 && c <= 8'h46) || (c >= 8'h61 && c <= 8'h66))
         r = {1'b1, c[3:0] + 4'd9};
      else
         r = 5'd0;
      return r;
   endfunction
endpackage

// File: rtl/hexlink_tx.sv
module hexlink_tx
   import hexlink_pkg::*;
#(
   parameter int ADDR_DIGITS = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     is_write,
   input  logic                     is_word,
   input  logic                     lo_byte,
   input  logic [4*ADDR_DIGITS-1:0] addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic                     tx_ready,
   output logic                     tx_valid,
   output logic [7:0]               tx_data,
   output logic                     sent
);
   localparam int MAX_LEN  = ADDR_DIGITS + 8;
   localparam int POS_W    = $clog2(MAX_LEN);
   localparam int ADDR_END = ADDR_DIGITS + 2;

   logic              active;
   logic [POS_W-1:0]  pos;
   logic [POS_W-1:0]  last_pos;
   logic [7:0]        letter;
   logic [DATA_W-1:0] dval;
   int                p_i;
   int                dd_i;

   always_comb begin
      dd_i     = is_word ? 4 : 2;
      p_i      = int'(pos);
      last_pos = is_write ? POS_W'(ADDR_END + 1 + dd_i) : POS_W'(ADDR_END);
      dval     = is_word ? wdata : {8'h00, wdata[7:0]};
      letter   = is_word ? 8'h77 : (lo_byte ? 8'h6C : 8'h68);
      if (is_write) letter = letter - 8'h20;
      if (p_i == 0)
         tx_data = letter;
      else if (p_i == 1)
         tx_data = ASC_SP;
      else if (p_i < ADDR_END)
         tx_data = nib_to_ascii(4'(addr >> (4 * (ADDR_END - 1 - p_i))));
      else if (p_i == ADDR_END)
         tx_data = is_write ? ASC_SP : ASC_NL;
      else if (p_i <= ADDR_END + dd_i)
         tx_data = nib_to_ascii(4'(dval >> (4 * (ADDR_END + dd_i - p_i))));
      else
         tx_data = ASC_NL;
   end

   assign tx_valid = active;
   assign sent     = active && tx_ready && (pos == last_pos);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         pos    <= '0;
      end else if (start) begin
         active <= 1'b1;
         pos    <= '0;
      end else if (active && tx_ready) begin
         if (pos == last_pos) active <= 1'b0;
         else                 pos    <= pos + 1'b1;
      end
   end

   assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
   assert_upper_hex_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !(tx_data >= 8'h61 && tx_data <= 8'h66));
endmodule

// File: rtl/hexlink_rx.sv
module hexlink_rx
   import hexlink_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              waiting,
   input  logic              is_read,
   input  logic              is_word,
   input  logic              flush,
   output logic              fin,
   output logic              fin_err,
   output logic [DATA_W-1:0] fin_data,
   output logic              irq
);
   prs_state_t        st, st_n;
   logic [DATA_W-1:0] acc, acc_n;
   logic [1:0]        cnt, cnt_n;
   logic [1:0]        last_dig;
   logic [4:0]        dec;
   logic              bad;

   always_comb begin
      st_n     = st;
      acc_n    = acc;
      cnt_n    = cnt;
      fin      = 1'b0;
      fin_err  = 1'b0;
      irq      = 1'b0;
      bad      = 1'b0;
      dec      = ascii_to_nib(rx_data);
      last_dig = is_word ? 2'd3 : 2'd1;
      if (rx_valid) begin
         unique case (st)
            PRS_LEAD:
               if (rx_data == ASC_IRQ) begin
                  irq  = 1'b1;
                  st_n = PRS_END_IRQ;
               end else if (waiting) begin
                  if (rx_data == ASC_OK)       st_n = is_read ? PRS_SEP : PRS_END_OK;
                  else if (rx_data == ASC_BAD) st_n = PRS_END_BAD;
                  else                         bad  = 1'b1;
               end
            PRS_SEP:
               if (rx_data == ASC_SP) begin
                  st_n  = PRS_DIG;
                  cnt_n = 2'd0;
                  acc_n = '0;
               end else bad = 1'b1;
            PRS_DIG:
               if (dec[4]) begin
                  acc_n = {acc[DATA_W-5:0], dec[3:0]};
                  cnt_n = cnt + 2'd1;
                  if (cnt == last_dig) st_n = PRS_END_OK;
               end else bad = 1'b1;
            PRS_END_OK:
               if (rx_data == ASC_NL) begin
                  fin  = 1'b1;
                  st_n = PRS_LEAD;
               end else bad = 1'b1;
            PRS_END_BAD:
               if (rx_data == ASC_NL) begin
                  fin     = 1'b1;
                  fin_err = 1'b1;
                  st_n    = PRS_LEAD;
               end else bad = 1'b1;
            PRS_END_IRQ:
               if (rx_data == ASC_NL) st_n = PRS_LEAD;
               else                   bad  = 1'b1;
            default: st_n = PRS_LEAD;
         endcase
      end
      if (bad) begin
         st_n    = PRS_LEAD;
         fin     = waiting;
         fin_err = waiting;
      end
      fin_data = acc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= PRS_LEAD;
         acc <= '0;
         cnt <= '0;
      end else begin
         st  <= flush ? PRS_LEAD : st_n;
         acc <= acc_n;
         cnt <= cnt_n;
      end
   end
endmodule

// File: rtl/hexlink_timer.sv
module hexlink_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [TMO_W-1:0] limit,
   output logic             expire
);
   logic [TMO_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!run)          cnt <= '0;
      else if (cnt != limit)  cnt <= cnt + 1'b1;
   end

   assign expire = run && (cnt == limit);

   assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      run && $past(run) && !$past(expire) |-> cnt == TMO_W'($past(cnt) + 1'b1));
endmodule

// File: rtl/hexlink_bridge.sv
module hexlink_bridge
   import hexlink_pkg::*;
#(
   parameter int ADDR_DIGITS = 7,
   parameter int TMO_W       = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic [1:0]               req_size,
   input  logic [4*ADDR_DIGITS-1:0] req_addr,
   input  logic [15:0]              req_wdata,
   input  logic [TMO_W-1:0]         tmo_limit,
   output logic                     tx_valid,
   input  logic                     tx_ready,
   output logic [7:0]               tx_data,
   input  logic                     rx_valid,
   input  logic [7:0]               rx_data,
   output logic                     done,
   output logic                     err,
   output logic [15:0]              rd_data,
   output logic                     irq_pulse
);
   localparam int ADDR_W = 4 * ADDR_DIGITS;

   generate
      if (ADDR_DIGITS < 1 || ADDR_DIGITS > 8) begin : g_bad_addr
         $error("hexlink_bridge: ADDR_DIGITS must lie in 1..8");
      end
      if (TMO_W < 2 || TMO_W > 32) begin : g_bad_tmo
         $error("hexlink_bridge: TMO_W must lie in 2..32");
      end
   endgenerate

   ctl_state_t        state;
   logic              c_write, c_word, c_lo;
   logic [ADDR_W-1:0] c_addr;
   logic [15:0]       c_wdata;
   logic              start, sent, fin, fin_err, irq_raw, expire, flush, complete, c_err;
   logic [15:0]       fin_data, fill, c_val;

   assign req_ready = (state == CTL_IDLE);
   assign start     = req_ready && req_valid;
   assign complete  = (state == CTL_WAIT) && (fin || expire);
   assign flush     = (state == CTL_WAIT) && expire && !fin;
   assign fill      = c_word ? 16'hFFFF : 16'h00FF;
   assign c_err     = fin ? fin_err : 1'b1;
   assign c_val     = c_err ? fill : (c_write ? 16'h0000 : fin_data);

   hexlink_tx #(.ADDR_DIGITS(ADDR_DIGITS)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(start), .is_write(c_write), .is_word(c_word),
      .lo_byte(c_lo), .addr(c_addr), .wdata(c_wdata), .tx_ready(tx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .sent(sent));

   hexlink_rx u_rx (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .waiting(state == CTL_WAIT), .is_read(!c_write), .is_word(c_word), .flush(flush),
      .fin(fin), .fin_err(fin_err), .fin_data(fin_data), .irq(irq_raw));

   hexlink_timer #(.TMO_W(TMO_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(state == CTL_WAIT), .limit(tmo_limit), .expire(expire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= CTL_IDLE;
         c_write   <= 1'b0;
         c_word    <= 1'b0;
         c_lo      <= 1'b0;
         c_addr    <= '0;
         c_wdata   <= '0;
         done      <= 1'b0;
         err       <= 1'b0;
         rd_data   <= '0;
         irq_pulse <= 1'b0;
      end else begin
         done      <= complete;
         irq_pulse <= irq_raw;
         if (complete) begin
            err     <= c_err;
            rd_data <= c_val;
         end
         unique case (state)
            CTL_IDLE: if (req_valid) begin
               c_write <= req_write;
               c_word  <= req_size[1];
               c_lo    <= req_size[0];
               c_addr  <= req_addr;
               c_wdata <= req_wdata;
               state   <= CTL_SEND;
            end
            CTL_SEND: if (sent) state <= CTL_WAIT;
            CTL_WAIT: if (complete) state <= CTL_IDLE;
            default:  state <= CTL_IDLE;
         endcase
      end
   end

   assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready && !tx_valid);
   assert_err_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done && err |-> (rd_data == 16'hFFFF || rd_data == 16'h00FF));
   assert_timeout_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> done && err);
   assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past(rx_valid && rx_data == ASC_IRQ));
endmodule

// File: tb/hexlink_bridge_bench.sv
module hexlink_bridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [27:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [15:0] tmo_limit = 16'd1000;
   logic        tx_ready = 1'b1;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic        req_ready, tx_valid, done, err, irq_pulse;
   logic [7:0]  tx_data;
   logic [15:0] rd_data;

   always #10 clk = ~clk;

   hexlink_bridge u_hexlink_bridge (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
      .req_wdata(req_wdata), .tmo_limit(tmo_limit), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
      .done(done), .err(err), .rd_data(rd_data), .irq_pulse(irq_pulse));

   int checks = 0, fails = 0;
   int done_cnt = 0, irq_cnt = 0, tx_n = 0, cyc = 0;
   bit bp = 1'b0;
   logic [15:0] last_data = '0;
   logic        last_err = 1'b0;
   logic [7:0]  txb [0:1023];

   // monitor: drives stall pattern and records traffic, all at the falling edge
   always @(negedge clk) begin
      cyc++;
      tx_ready = bp ? (cyc % 3 != 0) : 1'b1;
      if (tx_valid && tx_ready && tx_n < 1024) begin
         txb[tx_n] = tx_data;
         tx_n++;
      end
      if (done) begin
         done_cnt++;
         last_data = rd_data;
         last_err  = err;
      end
      if (irq_pulse) irq_cnt++;
   end

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic string cmd_text(bit wr, logic [1:0] sz, logic [27:0] a, logic [15:0] d);
      logic [7:0] c;
      string ah, dh, s;
      c = sz[1] ? 8'h77 : (sz[0] ? 8'h6C : 8'h68);
      if (wr) c = c - 8'd32;
      ah = $sformatf("%h", a);
      s  = $sformatf("%c %s", c, ah.toupper());
      if (wr) begin
         dh = sz[1] ? $sformatf("%h", d) : $sformatf("%h", d[7:0]);
         s  = {s, " ", dh.toupper()};
      end
      return {s, "\n"};
   endfunction

   int tx_base = 0;

   task automatic issue(input bit wr, input logic [1:0] sz, input logic [27:0] a,
                        input logic [15:0] d);
      @(negedge clk); #1;
      tx_base   = tx_n;
      req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
      req_valid = 1'b1;
      @(negedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic check_tx(input string exp, input string req);
      int i;
      for (i = 0; i < 400 && (tx_n - tx_base) < exp.len(); i++) begin
         @(negedge clk); #1;
      end
      begin
         bit ok = ((tx_n - tx_base) == exp.len());
         logic [7:0] av = 8'h00, ev = 8'h00;
         for (int k = 0; k < exp.len() && ok; k++)
            if (txb[tx_base + k] != exp.getc(k)) begin
               ok = 1'b0; av = txb[tx_base + k]; ev = exp.getc(k);
            end
         if ((tx_n - tx_base) != exp.len()) begin av = 8'(tx_n - tx_base); ev = 8'(exp.len()); end
         chk(ok, req, "command text", {24'h0, av}, {24'h0, ev});
      end
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk); #1;
      rx_valid = 1'b1; rx_data = b;
      @(negedge clk); #1;
      rx_valid = 1'b0;
   endtask

   task automatic put_str(input string s);
      for (int k = 0; k < s.len(); k++) put(s.getc(k));
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin @(negedge clk); #1; end
   endtask

   initial begin
      logic [27:0] a;
      logic [15:0] d, rv;
      string req, dig;
      int base, ibase, waited;

      idle(3);
      rst_n = 1'b1;
      idle(1);
      chk(req_ready && !tx_valid && !done && !err && rd_data == 16'h0 && !irq_pulse,
          "R11", "reset state", {req_ready, tx_valid, done, err, irq_pulse}, 32'h10);

      // sweep: direction x size code x value pattern
      for (int wr = 0; wr < 2; wr++)
         for (int sz = 0; sz < 4; sz++)
            for (int k = 0; k < 3; k++) begin
               a  = (k == 0) ? 28'h0 : (k == 1) ? 28'hFFFFFFF
                                      : 28'(32'h0A5C3E19 + sz * 32'h111 + wr);
               d  = (k == 0) ? 16'h0 : (k == 1) ? 16'hFFFF
                                      : 16'(16'h3B1D * (sz + 1) + wr * 7);
               bp = (k == 2);
               req = $sformatf("%s%s", wr ? "R2" : "R1 R3", (k == 2) ? " R4" : "");
               issue(wr[0], 2'(sz), a, d);
               check_tx(cmd_text(wr[0], 2'(sz), a, d), req);
               bp = 1'b0;
               base = done_cnt;
               if (wr != 0) begin
                  put_str("o\n");
                  idle(1);
                  chk(done_cnt == base + 1 && !last_err && last_data == 16'h0, "R6",
                      "write ok", {15'h0, last_err, last_data}, 32'h0);
               end else begin
                  rv  = (sz >= 2) ? d : {8'h00, d[7:0]};
                  dig = (sz >= 2) ? $sformatf("%h", d) : $sformatf("%h", d[7:0]);
                  if (k != 2) dig = dig.toupper();
                  put_str({"o ", dig, "\n"});
                  idle(1);
                  chk(done_cnt == base + 1 && !last_err && last_data == rv, "R5 R12",
                      "read value", {15'h0, last_err, last_data}, {16'h0, rv});
               end
            end

      // R12: result holds, no extra strobe
      idle(5);
      chk(!done && rd_data == last_data, "R12", "result held", {16'h0, rd_data}, {16'h0, last_data});

      // R11: busy while sending
      issue(1'b0, 2'd1, 28'h0000123, 16'h0);
      chk(!req_ready && tx_valid, "R11", "busy after accept", {req_ready, tx_valid}, 32'h1);
      check_tx(cmd_text(1'b0, 2'd1, 28'h0000123, 16'h0), "R1");
      base = done_cnt;
      // R7: refusal
      put_str("x\n");
      idle(1);
      chk(done_cnt == base + 1 && last_err && last_data == 16'h00FF, "R7", "refused byte",
          {15'h0, last_err, last_data}, 32'h1_00FF);

      // R8: bad digit mid reply, completes on that byte
      issue(1'b0, 2'd2, 28'h0BEEF01, 16'h0);
      check_tx(cmd_text(1'b0, 2'd2, 28'h0BEEF01, 16'h0), "R1");
      base = done_cnt;
      put_str("o 1");
      put(8'h67);
      chk(done_cnt == base + 1 && last_err && last_data == 16'hFFFF, "R8", "bad digit",
          {15'h0, last_err, last_data}, 32'h1_FFFF);

      // R8: unknown lead character on a write
      issue(1'b1, 2'd0, 28'h0000042, 16'h00A7);
      check_tx(cmd_text(1'b1, 2'd0, 28'h0000042, 16'h00A7), "R2");
      base = done_cnt;
      put(8'h71);
      chk(done_cnt == base + 1 && last_err && last_data == 16'h00FF, "R8", "bad lead",
          {15'h0, last_err, last_data}, 32'h1_00FF);

      // R9: interrupt notice while waiting does not end the wait
      issue(1'b1, 2'd2, 28'h1234567, 16'hC0DE);
      check_tx(cmd_text(1'b1, 2'd2, 28'h1234567, 16'hC0DE), "R2");
      base = done_cnt; ibase = irq_cnt;
      put_str("i\n");
      idle(3);
      chk(irq_cnt == ibase + 1 && done_cnt == base, "R9", "irq while waiting",
          irq_cnt - ibase, 32'h1);
      put_str("o\n");
      idle(1);
      chk(done_cnt == base + 1 && !last_err, "R9", "wait continued", done_cnt - base, 32'h1);

      // R9 / R11: idle traffic
      base = done_cnt; ibase = irq_cnt;
      put_str("i\n");
      put_str("o\nx\n");
      idle(3);
      chk(irq_cnt == ibase + 1, "R9", "irq while idle", irq_cnt - ibase, 32'h1);
      chk(done_cnt == base && req_ready, "R11", "idle bytes ignored", done_cnt - base, 32'h0);

      // R10: timeout, exact completion edge
      tmo_limit = 16'd20;
      issue(1'b0, 2'd3, 28'h7777777, 16'h0);
      check_tx(cmd_text(1'b0, 2'd3, 28'h7777777, 16'h0), "R1");
      base = done_cnt; waited = 0;
      for (int k = 1; k <= 60 && waited == 0; k++) begin
         @(negedge clk); #1;
         if (done_cnt != base) waited = k;
      end
      chk(waited == 22, "R10", "timeout cycle", waited, 32'd22);
      chk(last_err && last_data == 16'hFFFF, "R10", "timeout word fill",
          {15'h0, last_err, last_data}, 32'h1_FFFF);
      issue(1'b0, 2'd0, 28'h0000001, 16'h0);
      check_tx(cmd_text(1'b0, 2'd0, 28'h0000001, 16'h0), "R1");
      base = done_cnt;
      idle(30);
      chk(done_cnt == base + 1 && last_err && last_data == 16'h00FF, "R10", "timeout byte fill",
          {15'h0, last_err, last_data}, 32'h1_00FF);
      tmo_limit = 16'd1000;

      summary();
   end
endmodule